// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block holds the eight-bit modem status word of one serial channel. The upper nibble shows the live, active-high state of four active-low modem lines: clear-to-send, data-set-ready, ring indicator and carrier detect. The lower nibble holds four sticky change flags. Software reads the word through a one-cycle read strobe. The read returns the word as it stands in that cycle and clears the flags at the closing clock edge.

The pins pass through a multi-flop synchronizer before they reach the selector. When the loopback enable is high, the selector takes the upper nibble from four modem-control outputs instead of the pins. The change detector compares the selected value with its value one cycle earlier. A swap of source therefore raises flags exactly as a pin change would. An interrupt request stays high while any flag is set.

Flag detection is gated by a two-state controller. In `ST_FILL`, entered on reset, the detector only tracks the selected value and never sets a flag. It counts clock edges while the synchronizer fills. The transition `FILL_DONE` moves it to `ST_ARMED` once SYNC_STAGES+1 edges have passed, and it then stays in `ST_ARMED` until the next reset.

Top module: `modem_status_reg`

## Requirements
- R1: With `loop_en` low, `rd_data[4]`, `[5]`, `[6]` and `[7]` are the inverses of `cts_n`, `dsr_n`, `ri_n` and `cd_n` respectively.
- R2: With `loop_en` high, `rd_data[4]` equals `mcr_bits[1]`, `rd_data[5]` equals `mcr_bits[0]`, `rd_data[6]` equals `mcr_bits[2]` and `rd_data[7]` equals `mcr_bits[3]`, with no added latency.
- R3: `rd_data[0]`, `[1]` and `[3]` set when the selected clear-to-send, data-set-ready or carrier-detect bit (`rd_data[4]`, `[5]`, `[7]`) changes in either direction.
- R4: `rd_data[2]` sets only when the selected ring bit `rd_data[6]` falls from 1 to 0, never when it rises.
- R5: Flags stay set until a cycle with `rd_stb` high. That edge clears all four flags, except any flag whose change is detected at that same edge, which stays set.
- R6: `irq` is high exactly when any of `rd_data[3:0]` is 1.
- R7: After reset the flags and `irq` are 0 and the upper nibble is 0 until the synchronizer fills. No flag sets during the SYNC_STAGES+1 edges after reset, even if the pins are asserted.
- R8: A pin change shows in `rd_data` after SYNC_STAGES clock edges and sets its flag one edge later. A loopback source change shows at once and sets its flag at the next edge.
- R9: While `loop_en` is high, pin changes do not alter `rd_data` or `irq`. Turning loopback on or off sets the flags of the bits whose value differs between the two sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| mcr_bits | input | 4 | Modem-control outputs used as the loopback source |
| loop_en | input | 1 | Selects the loopback source when high |
| rd_stb | input | 1 | One-cycle read of the status word; clears flags |
| rd_data | output | 8 | Status word: line states in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that `mcr_bits`, `loop_en` and `rd_stb` are synchronous to `clk`. Only the four pins may change at arbitrary times. They also assume that the synchronizer has the default depth of two, so that the fill window closes before any pin edge must be flagged. The bench drives every input at the falling edge. It holds the pins steady through each reset, and it makes no flag-bearing change until well after the fill window has closed.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int unsigned NUM_LINES = 4;

    // line index order inside the block; also the order of status/flag bits
    localparam int unsigned LINE_CTS = 0;
    localparam int unsigned LINE_DSR = 1;
    localparam int unsigned LINE_RI  = 2;
    localparam int unsigned LINE_CD  = 3;

    // lines whose flag fires only on the 1->0 transition of the status bit
    localparam logic [NUM_LINES-1:0] TRAIL_ONLY_MASK = 4'b0100;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_ARMED = 1'b1
    } msr_state_e;

    // modem-control bit that feeds each line in loopback
    function automatic int unsigned loop_src_bit(input int unsigned line);
        case (line)
            LINE_CTS: return 1;
            LINE_DSR: return 0;
            LINE_RI:  return 2;
            default:  return 3;
        endcase
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
    import msr_pkg::*;
(
    input  logic                 loop_en,
    input  logic [NUM_LINES-1:0] pin_stat,
    input  logic [3:0]           mcr_bits,
    output logic [NUM_LINES-1:0] sel_stat
);
    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            localparam int unsigned SRC = loop_src_bit(i);
            assign sel_stat[i] = loop_en ? mcr_bits[SRC] : pin_stat[i];
        end
    endgenerate
endmodule

// File: rtl/msr_change_fsm.sv
module msr_change_fsm
    import msr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] cur_stat,
    input  logic                 rd_stb,
    output logic [NUM_LINES-1:0] flags
);
    localparam int unsigned FILL_LEN = SYNC_STAGES;
    localparam int unsigned CNT_W    = $clog2(FILL_LEN + 1) + 1;

    msr_state_e            state_q, state_d;
    logic [CNT_W-1:0]      fill_cnt_q;
    logic                  armed;
    logic [NUM_LINES-1:0]  prev_q;
    logic [NUM_LINES-1:0]  delta;
    logic [NUM_LINES-1:0]  flags_q, flags_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_FILL;
            fill_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL)
                fill_cnt_q <= fill_cnt_q + 1'b1;
        end
    end

    // next state and outputs of the controller
    always_comb begin
        state_d = state_q;
        armed   = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (fill_cnt_q == CNT_W'(FILL_LEN))
                    state_d = ST_ARMED;          // FILL_DONE
            end
            ST_ARMED: begin
                armed = 1'b1;
            end
        endcase
    end

    // per-line change detection
    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_det
            if (TRAIL_ONLY_MASK[i]) begin : g_trail
                assign delta[i] = prev_q[i] & ~cur_stat[i];
            end else begin : g_both
                assign delta[i] = prev_q[i] ^ cur_stat[i];
            end
        end
    endgenerate

    always_comb begin
        flags_d = flags_q;
        if (rd_stb)
            flags_d = '0;
        if (armed)
            flags_d = flags_d | delta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= cur_stat;
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (flags_q == '0));  // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !rd_stb) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));  // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && rd_stb && delta == '0) |=> (flags_q == '0));  // R5

    AST_RI_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_q[LINE_RI] && cur_stat[LINE_RI]) |=> !flags_q[LINE_RI]);  // R4

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       cd_n,
    input  logic [3:0] mcr_bits,
    input  logic       loop_en,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    output logic       irq
);
    logic [NUM_LINES-1:0] raw_stat;
    logic [NUM_LINES-1:0] pin_stat;
    logic [NUM_LINES-1:0] sel_stat;
    logic [NUM_LINES-1:0] flags;

    // active-low pins turned into active-high status, in line order
    assign raw_stat[LINE_CTS] = ~cts_n;
    assign raw_stat[LINE_DSR] = ~dsr_n;
    assign raw_stat[LINE_RI]  = ~ri_n;
    assign raw_stat[LINE_CD]  = ~cd_n;

    msr_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_stat),
        .dout (pin_stat)
    );

    msr_src_sel u_sel (
        .loop_en (loop_en),
        .pin_stat(pin_stat),
        .mcr_bits(mcr_bits),
        .sel_stat(sel_stat)
    );

    msr_change_fsm #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_stat(sel_stat),
        .rd_stb  (rd_stb),
        .flags   (flags)
    );

    assign rd_data = {sel_stat, flags};
    assign irq     = |flags;

    AST_LOOP_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (rd_data[4] == mcr_bits[1]));  // R2
    AST_LOOP_DSR: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (rd_data[5] == mcr_bits[0]));  // R2
    AST_LOOP_RI: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (rd_data[6] == mcr_bits[2]));  // R2
    AST_LOOP_CD: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (rd_data[7] == mcr_bits[3]));  // R2
    AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (rd_data[3:0] != 4'b0));  // R6

endmodule

// File: tb/tb_modem_status_reg.sv
`timescale 1ns/1ps
module tb_modem_status_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pn = 4'hF;      // [0]=cts_n [1]=dsr_n [2]=ri_n [3]=cd_n
    logic [3:0] mcr = 4'h0;
    logic       loop_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    modem_status_reg dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_n   (pn[0]),
        .dsr_n   (pn[1]),
        .ri_n    (pn[2]),
        .cd_n    (pn[3]),
        .mcr_bits(mcr),
        .loop_en (loop_en),
        .rd_stb  (rd_stb),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // {loop, mcr[3:0], pins_n[3:0], read, expected rd_data[7:0], expected irq}
    localparam logic [18:0] VECS [16] = '{
        {1'b0, 4'h0, 4'hF, 1'b0, 8'h00, 1'b0},  // idle                       R1
        {1'b0, 4'h0, 4'hE, 1'b1, 8'h11, 1'b1},  // CTS asserted               R1 R3
        {1'b0, 4'h0, 4'hE, 1'b0, 8'h10, 1'b0},  // flags gone after read      R5
        {1'b0, 4'h0, 4'hC, 1'b1, 8'h32, 1'b1},  // DSR asserted               R3
        {1'b0, 4'h0, 4'h8, 1'b0, 8'h70, 1'b0},  // RI leading edge: no flag   R4
        {1'b0, 4'h0, 4'hC, 1'b0, 8'h34, 1'b1},  // RI trailing edge           R4
        {1'b0, 4'h0, 4'h4, 1'b1, 8'hBC, 1'b1},  // CD asserted, RI still held R5
        {1'b0, 4'h0, 4'hF, 1'b1, 8'h0B, 1'b1},  // all released               R3
        {1'b1, 4'h0, 4'h0, 1'b0, 8'h00, 1'b0},  // loop on, pins ignored      R9
        {1'b1, 4'h2, 4'h0, 1'b1, 8'h11, 1'b1},  // RTS -> CTS                 R2
        {1'b1, 4'h1, 4'h0, 1'b1, 8'h23, 1'b1},  // DTR -> DSR                 R2
        {1'b1, 4'h4, 4'h0, 1'b1, 8'h42, 1'b1},  // OP1 -> RI                  R2
        {1'b1, 4'h8, 4'h0, 1'b1, 8'h8C, 1'b1},  // OPA/B -> CD                R2 R4
        {1'b0, 4'h8, 4'h0, 1'b1, 8'hF3, 1'b1},  // leave loopback             R9
        {1'b1, 4'hF, 4'h0, 1'b0, 8'hF0, 1'b0},  // enter loopback, equal      R9
        {1'b0, 4'hF, 4'hF, 1'b1, 8'h0F, 1'b1}   // leave loopback, all differ R9
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        ticks(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state, pins idle
        apply_reset();
        check("R7", "reset rd_data", rd_data, 8'h00);
        check("R6", "reset irq", {7'b0, irq}, 8'h00);
        ticks(6);

        // table walk
        for (int k = 0; k < 16; k++) begin
            loop_en = VECS[k][18];
            mcr     = VECS[k][17:14];
            pn      = VECS[k][13:10];
            ticks(5);
            check("R1/R2/R3/R4/R9", $sformatf("vec %0d rd_data", k), rd_data, VECS[k][8:1]);
            check("R6", $sformatf("vec %0d irq", k), {7'b0, irq}, {7'b0, VECS[k][0]});
            if (VECS[k][9]) begin
                do_read();
                check("R5", $sformatf("vec %0d flags after read", k), {4'h0, rd_data[3:0]}, 8'h00);
                check("R6", $sformatf("vec %0d irq after read", k), {7'b0, irq}, 8'h00);
            end
        end

        // R5: change detected in the read cycle survives the read
        loop_en = 1'b1;
        mcr = 4'h0;
        ticks(3);
        do_read();
        check("R5", "pre-clear", rd_data, 8'h00);
        mcr = 4'h2;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R5", "same-cycle change kept", rd_data, 8'h11);
        do_read();
        check("R5", "cleared by later read", rd_data, 8'h10);

        // R9: pins ignored while looped back
        pn = 4'h0;
        ticks(5);
        check("R9", "pins ignored in loopback", rd_data, 8'h10);
        check("R9", "no irq from pins in loopback", {7'b0, irq}, 8'h00);
        pn = 4'hF;
        ticks(5);
        loop_en = 1'b0;
        ticks(1);
        check("R9", "leave loopback flags CTS", rd_data, 8'h01);
        do_read();

        // R8: synchronizer latency, then flag one edge later
        pn[0] = 1'b0;
        @(negedge clk);
        check("R8", "one edge: not yet visible", rd_data, 8'h00);
        @(negedge clk);
        check("R8", "two edges: status visible", rd_data, 8'h10);
        @(negedge clk);
        check("R8", "three edges: flag set", rd_data, 8'h11);
        check("R6", "irq with flag", {7'b0, irq}, 8'h01);
        do_read();

        // R8: loopback source visible with no latency
        loop_en = 1'b1;
        mcr = 4'h8;
        #1;
        check("R8", "loopback immediate", rd_data[7:4], 4'h8);
        @(negedge clk);
        check("R8", "loopback flag next edge", rd_data, 8'h89);
        loop_en = 1'b0;
        mcr = 4'h0;

        // R7: reset with all pins asserted must not set flags
        pn = 4'h0;
        apply_reset();
        check("R7", "reset with pins asserted", rd_data, 8'h00);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check("R7", $sformatf("fill cycle %0d flags", c), {4'h0, rd_data[3:0]}, 8'h00);
        end
        check("R7", "after fill status", rd_data, 8'hF0);
        check("R7", "after fill irq", {7'b0, irq}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule